// File: doc/BRIEF.md
# Three-Share Masked AND-XOR Gate

This block evaluates the Boolean function x XOR (y AND z) on a vector of bits while every variable stays split into three Boolean shares. The three shares of a variable XOR together to its plain value. None of the three share functions reads all of a variable's shares. Each function uses only two of the three share indices, so no single function sees every share of any variable. The result of each function goes straight into its own register. Glitches inside one function therefore cannot combine all the shares of a secret. Every bit position of the `WIDTH`-wide vectors is handled independently.

The gate has a quadratic term, so it needs three shares at minimum. The output sharing of the bare functions is not guaranteed to be uniform. An optional refresh therefore adds two fresh random bits per position before the registers. It XORs the first random vector into share 1 and the second into share 2. Share 3 takes the XOR of both vectors, so the plain value stays the same.

The block accepts a beat with a valid/ready handshake and presents the result one cycle later. It holds the result while the consumer stalls. A producer can feed it a new beat every cycle as long as the consumer keeps accepting.

Top module: `tis_andxor_gate`

## Requirements
- R1: For every bit position, the XOR of o_s1, o_s2 and o_s3 equals x XOR (y AND z), with x = x_s1^x_s2^x_s3 and likewise for y and z. This holds with the refresh on and with it off.
- R2: With refresh off, o_s1 = x_s2 ^ (y_s2&z_s2) ^ (y_s2&z_s3) ^ (y_s3&z_s2). The share-1 inputs x_s1, y_s1 and z_s1 have no effect on o_s1.
- R3: With refresh off, o_s2 = x_s3 ^ (y_s3&z_s3) ^ (y_s3&z_s1) ^ (y_s1&z_s3). The share-2 inputs have no effect on o_s2.
- R4: With refresh off, o_s3 = x_s1 ^ (y_s1&z_s1) ^ (y_s1&z_s2) ^ (y_s2&z_s1). The share-3 inputs have no effect on o_s3.
- R5: With remask_en high when a beat is accepted, o_s1 gets an extra XOR with rnd_a and o_s2 with rnd_b. o_s3 gets an extra XOR with rnd_a^rnd_b.
- R6: With remask_en low when a beat is accepted, rnd_a and rnd_b have no effect on any output share.
- R7: A beat is accepted on a rising clock edge where in_valid and in_ready are both high. From that edge on, out_valid is high and the output shares carry that beat's result.
- R8: While out_valid is high and out_ready is low, out_valid and all output shares keep their values, and in_ready is low.
- R9: in_ready is high whenever out_valid is low or out_ready is high. If out_ready is high and no new beat is accepted, out_valid falls on the next edge.
- R10: While rst_n is low, out_valid and all output shares are zero. This takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| x_s1 | input | WIDTH | Share 1 of x |
| x_s2 | input | WIDTH | Share 2 of x |
| x_s3 | input | WIDTH | Share 3 of x |
| y_s1 | input | WIDTH | Share 1 of y |
| y_s2 | input | WIDTH | Share 2 of y |
| y_s3 | input | WIDTH | Share 3 of y |
| z_s1 | input | WIDTH | Share 1 of z |
| z_s2 | input | WIDTH | Share 2 of z |
| z_s3 | input | WIDTH | Share 3 of z |
| remask_en | input | 1 | Apply the fresh-randomness refresh to the accepted beat |
| rnd_a | input | WIDTH | Fresh random bits for the refresh |
| rnd_b | input | WIDTH | Fresh random bits for the refresh |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| o_s1 | output | WIDTH | Share 1 of the result |
| o_s2 | output | WIDTH | Share 2 of the result |
| o_s3 | output | WIDTH | Share 3 of the result |

## Verification
The reference model predicts each output share exactly, not only the reconstructed value. If one cross term had its share indices rotated, the reconstruction could still come out right for some inputs, but the per-share comparison would catch the error.

Directed beats change only the share index that a function must not read and confirm that the matching output share stays the same. A gate that leaked a forbidden index would change there. Other directed beats repeat the same data with new random bits while the refresh is off. A refresh that ignored its enable would change the shares there.

Random stalls cover the hold behaviour. A design that loaded while stalled would overwrite a pending result. One that dropped out_valid would lose it. A reset asserted between clock edges checks that clearing does not wait for a clock edge.

// File: rtl/tis_pkg.sv
package tis_pkg;
  // number of shares per variable; degree-2 gate needs d+1 = 3
  localparam int unsigned NUM_SHARES = 3;

  // share index used as the "first" operand of component function i
  function automatic int unsigned idx_a(input int unsigned i);
    return (i + 1) % NUM_SHARES;
  endfunction

  // share index used as the "second" operand of component function i
  function automatic int unsigned idx_b(input int unsigned i);
    return (i + 2) % NUM_SHARES;
  endfunction
endpackage

// File: rtl/tis_component.sv
// One non-complete component function: reads two share indices only.
module tis_component #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_a,
  input  logic [WIDTH-1:0] y_a,
  input  logic [WIDTH-1:0] y_b,
  input  logic [WIDTH-1:0] z_a,
  input  logic [WIDTH-1:0] z_b,
  output logic [WIDTH-1:0] f_out
);
  logic [WIDTH-1:0] t_aa, t_ab, t_ba;

  always_comb begin
    t_aa  = y_a & z_a;
    t_ab  = y_a & z_b;
    t_ba  = y_b & z_a;
    f_out = x_a ^ t_aa ^ t_ab ^ t_ba;
  end
endmodule

// File: rtl/tis_refresh.sv
// Builds per-share masks whose XOR is zero; all zero when disabled.
module tis_refresh #(
  parameter int unsigned WIDTH = 8
) (
  input  logic                                   enable,
  input  logic [WIDTH-1:0]                       rnd_a,
  input  logic [WIDTH-1:0]                       rnd_b,
  output logic [tis_pkg::NUM_SHARES-1:0][WIDTH-1:0] mask
);
  logic [WIDTH-1:0] m_a, m_b;

  always_comb begin
    m_a     = enable ? rnd_a : '0;
    m_b     = enable ? rnd_b : '0;
    mask[0] = m_a;
    mask[1] = m_b;
    mask[2] = m_a ^ m_b;
  end
endmodule

// File: rtl/tis_share_reg.sv
// Output register of one share, with explicit load enable.
module tis_share_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_next;

  always_comb begin
    q_next = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/tis_andxor_gate.sv
module tis_andxor_gate #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] x_s1,
  input  logic [WIDTH-1:0] x_s2,
  input  logic [WIDTH-1:0] x_s3,
  input  logic [WIDTH-1:0] y_s1,
  input  logic [WIDTH-1:0] y_s2,
  input  logic [WIDTH-1:0] y_s3,
  input  logic [WIDTH-1:0] z_s1,
  input  logic [WIDTH-1:0] z_s2,
  input  logic [WIDTH-1:0] z_s3,
  input  logic             remask_en,
  input  logic [WIDTH-1:0] rnd_a,
  input  logic [WIDTH-1:0] rnd_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] o_s1,
  output logic [WIDTH-1:0] o_s2,
  output logic [WIDTH-1:0] o_s3
);
  import tis_pkg::*;
  localparam int unsigned NS = NUM_SHARES;

  logic [NS-1:0][WIDTH-1:0] xs, ys, zs, fs, mk, share_d, share_q;
  logic valid_q, valid_next, load;

  always_comb begin
    xs[0] = x_s1; xs[1] = x_s2; xs[2] = x_s3;
    ys[0] = y_s1; ys[1] = y_s2; ys[2] = y_s3;
    zs[0] = z_s1; zs[1] = z_s2; zs[2] = z_s3;
  end

  // handshake control
  always_comb begin
    in_ready   = !valid_q || out_ready;
    load       = in_valid && in_ready;
    valid_next = valid_q;
    if (load)           valid_next = 1'b1;
    else if (out_ready) valid_next = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_next;
  end

  tis_refresh #(.WIDTH(WIDTH)) u_refresh (
    .enable (remask_en),
    .rnd_a  (rnd_a),
    .rnd_b  (rnd_b),
    .mask   (mk)
  );

  for (genvar i = 0; i < NS; i++) begin : g_share
    localparam int unsigned A = idx_a(i);
    localparam int unsigned B = idx_b(i);

    tis_component #(.WIDTH(WIDTH)) u_func (
      .x_a   (xs[A]),
      .y_a   (ys[A]),
      .y_b   (ys[B]),
      .z_a   (zs[A]),
      .z_b   (zs[B]),
      .f_out (fs[i])
    );

    always_comb share_d[i] = fs[i] ^ mk[i];

    tis_share_reg #(.WIDTH(WIDTH)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .d     (share_d[i]),
      .q     (share_q[i])
    );
  end

  always_comb begin
    out_valid = valid_q;
    o_s1      = share_q[0];
    o_s2      = share_q[1];
    o_s3      = share_q[2];
  end

  // ---------------- assertions ----------------
  // R1 / R5: reconstruction of accepted beat matches the plain function
  p_reconstruct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((o_s1 ^ o_s2 ^ o_s3) ==
      $past((x_s1 ^ x_s2 ^ x_s3) ^ ((y_s1 ^ y_s2 ^ y_s3) & (z_s1 ^ z_s2 ^ z_s3)))));

  // R2: share 1 without refresh uses index 2 and 3 only
  p_share1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !remask_en) |=>
      (o_s1 == $past(x_s2 ^ (y_s2 & z_s2) ^ (y_s2 & z_s3) ^ (y_s3 & z_s2))));

  // R7: accepted beat is presented on the next edge
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8: stalled output holds
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(o_s1) && $stable(o_s2) && $stable(o_s3)));

  // R8: no acceptance while stalled
  p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: drained output without new beat clears valid
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !in_valid) |=> !out_valid);
endmodule

// File: tb/tis_andxor_gate_tb.sv
module tis_andxor_gate_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready, remask_en;
  logic [W-1:0] xs [3];
  logic [W-1:0] ys [3];
  logic [W-1:0] zs [3];
  logic [W-1:0] ra, rb;
  logic [W-1:0] o1, o2, o3;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  tis_andxor_gate #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .x_s1(xs[0]), .x_s2(xs[1]), .x_s3(xs[2]),
    .y_s1(ys[0]), .y_s2(ys[1]), .y_s3(ys[2]),
    .z_s1(zs[0]), .z_s2(zs[1]), .z_s3(zs[2]),
    .remask_en(remask_en), .rnd_a(ra), .rnd_b(rb),
    .out_valid(out_valid), .out_ready(out_ready),
    .o_s1(o1), .o_s2(o2), .o_s3(o3));

  // ---------------- reference model ----------------
  logic         m_valid;
  logic         m_rm;
  logic [W-1:0] m_s [3];
  logic [W-1:0] m_plain;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 1'b0; m_rm = 1'b0; m_plain = '0;
      for (int i = 0; i < 3; i++) m_s[i] = '0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      m_s[0] = xs[1] ^ (ys[1] & zs[1]) ^ (ys[1] & zs[2]) ^ (ys[2] & zs[1]);
      m_s[1] = xs[2] ^ (ys[2] & zs[2]) ^ (ys[2] & zs[0]) ^ (ys[0] & zs[2]);
      m_s[2] = xs[0] ^ (ys[0] & zs[0]) ^ (ys[0] & zs[1]) ^ (ys[1] & zs[0]);
      if (remask_en) begin
        m_s[0] = m_s[0] ^ ra;
        m_s[1] = m_s[1] ^ rb;
        m_s[2] = m_s[2] ^ ra ^ rb;
      end
      m_rm    = remask_en;
      m_plain = (xs[0] ^ xs[1] ^ xs[2]) ^ ((ys[0] ^ ys[1] ^ ys[2]) & (zs[0] ^ zs[1] ^ zs[2]));
      m_valid = 1'b1;
    end else if (out_ready) begin
      m_valid = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (time %0t)", req, act, exp, $time);
    end
  endtask

  // compare every port against the model
  task automatic check_all();
    chk("R7 R9 out_valid", W'(out_valid), W'(m_valid));
    chk("R8 R9 in_ready", W'(in_ready), W'(!m_valid || out_ready));
    chk(m_rm ? "R5 share1" : "R2 share1", o1, m_s[0]);
    chk(m_rm ? "R5 share2" : "R3 share2", o2, m_s[1]);
    chk(m_rm ? "R5 share3" : "R4 share3", o3, m_s[2]);
    if (m_valid) chk("R1 reconstruct", o1 ^ o2 ^ o3, m_plain);
  endtask

  task automatic share_rand(input logic [W-1:0] x, input logic [W-1:0] y, input logic [W-1:0] z);
    xs[0] = W'($urandom); xs[1] = W'($urandom); xs[2] = x ^ xs[0] ^ xs[1];
    ys[0] = W'($urandom); ys[1] = W'($urandom); ys[2] = y ^ ys[0] ^ ys[1];
    zs[0] = W'($urandom); zs[1] = W'($urandom); zs[2] = z ^ zs[0] ^ zs[1];
  endtask

  // one accepted beat; returns the three output shares
  task automatic beat(output logic [W-1:0] r1, output logic [W-1:0] r2, output logic [W-1:0] r3);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    check_all();
    r1 = o1; r2 = o2; r3 = o3;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL R7: watchdog expired, actual cycle %0d expected below 50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a1, a2, a3, b1, b2, b3;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; remask_en = 1'b0;
    ra = '0; rb = '0;
    for (int i = 0; i < 3; i++) begin xs[i] = '1; ys[i] = '1; zs[i] = '1; end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_valid", W'(out_valid), '0);
    chk("R10 share1", o1, '0);
    chk("R10 share2", o2, '0);
    chk("R10 share3", o3, '0);
    rst_n = 1'b1;

    // random traffic, refresh mixed, random stalls
    for (int n = 0; n < 600; n++) begin
      share_rand(W'($urandom), W'($urandom), W'($urandom));
      ra = W'($urandom); rb = W'($urandom);
      remask_en = (n < 200) ? 1'b0 : (n < 400) ? 1'b1 : 1'($urandom);
      in_valid  = ($urandom % 5) != 0;
      out_ready = ($urandom % 3) != 0;
      @(negedge clk);
      check_all();
    end

    // exhaustive plain values for a single-bit view, all bits set alike
    for (int v = 0; v < 8; v++) begin
      remask_en = v[0];
      ra = W'($urandom); rb = W'($urandom);
      share_rand({W{v[2]}}, {W{v[1]}}, {W{v[0]}});
      beat(a1, a2, a3);
    end

    // R2/R3/R4: vary only the forbidden index of each share
    remask_en = 1'b0;
    share_rand(W'($urandom), W'($urandom), W'($urandom));
    beat(a1, a2, a3);
    for (int k = 0; k < 3; k++) begin
      xs[k] = ~xs[k]; ys[k] = W'($urandom); zs[k] = W'($urandom);
      beat(b1, b2, b3);
      if (k == 0) chk("R2 index-1 inputs ignored", b1, a1);
      if (k == 1) chk("R3 index-2 inputs ignored", b2, a2);
      if (k == 2) chk("R4 index-3 inputs ignored", b3, a3);
      a1 = b1; a2 = b2; a3 = b3;
    end

    // R6: refresh off, new random bits change nothing
    remask_en = 1'b0;
    ra = 8'h5a; rb = 8'hc3;
    beat(a1, a2, a3);
    ra = 8'ha5; rb = 8'h3c;
    beat(b1, b2, b3);
    chk("R6 share1", b1, a1);
    chk("R6 share2", b2, a2);
    chk("R6 share3", b3, a3);

    // R8: long stall keeps the result
    share_rand(8'hf0, 8'h0f, 8'hff);
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk); check_all();
    a1 = o1;
    share_rand(8'h00, 8'h00, 8'h00);
    repeat (5) begin @(negedge clk); check_all(); end
    chk("R8 held share1", o1, a1);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk); check_all();
    chk("R9 drained", W'(out_valid), '0);

    // R10: asynchronous reset between edges
    in_valid = 1'b1;
    share_rand(8'h3c, 8'hff, 8'h99);
    @(negedge clk); check_all();
    #1 rst_n = 1'b0;
    #1;
    chk("R10 async out_valid", W'(out_valid), '0);
    chk("R10 async share", o1 | o2 | o3, '0);
    @(negedge clk);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk); check_all();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule